// File: doc/BRIEF.md
# Stochastic Up/Down Counter Integrator

This block integrates the difference between two stochastic bitstreams. Each clock cycle it looks at one bit from an "up" stream and one bit from a "down" stream. It moves a saturating counter of N bits up by one, down by one, or leaves it where it is. The counter value I stands for the unipolar quantity I/2^N. The counter therefore gives a fresh Euler-step estimate of the solution of dy/dt = pa - pb in every cycle. There is no need to wait for the end of a long stream.

An initial condition is written into the counter with a synchronous load, in the same units as the counter. An optional output stage turns the counter back into a bitstream. It compares the counter with a random word supplied from outside and emits 1 when the counter is strictly greater. That stream can be fed back, or passed to a following integrator. A parameter removes the output stage entirely when no stream is needed. Random number generation lives outside the block. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `sc_integrator`

## Requirements
- R1: While reset is asserted, and for the idle cycles after its release, the counter reads 0 and the output stream bit is 0.
- R2: In a cycle with up_bit=1, dn_bit=0 and no load, the counter increases by exactly one at the next clock edge.
- R3: In a cycle with up_bit=0, dn_bit=1 and no load, the counter decreases by exactly one at the next clock edge.
- R4: When up_bit equals dn_bit (both 0 or both 1) and no load is requested, the counter keeps its value.
- R5: An up step with the counter at 2^N-1 leaves the counter at 2^N-1; it never wraps to 0.
- R6: A down step with the counter at 0 leaves the counter at 0; it never wraps to 2^N-1.
- R7: With load_en=1, the counter takes load_val at the next edge, whatever up_bit and dn_bit are in that cycle.
- R8: With the output stage present (OUT_EN=1), stream_bit is 1 exactly when the unsigned counter value is strictly greater than the unsigned rand_word in the same cycle. With OUT_EN=0, stream_bit is constantly 0.
- R9: Over k cycles without load and without reaching a bound, the counter equals its initial value plus the number of up-only cycles minus the number of down-only cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_en | input | 1 | Synchronous load of the initial value; has priority over any step |
| load_val | input | N | Initial counter value, in counter units |
| up_bit | input | 1 | Bit of the increment control stream |
| dn_bit | input | 1 | Bit of the decrement control stream |
| rand_word | input | N | Random word for the output comparator |
| count | output | N | Present counter value I |
| stream_bit | output | 1 | Output stream bit: count > rand_word (0 when the output stage is removed) |

## Verification
A load and a step can arrive in the same cycle. So can a step and a bound of the counter. The bench drives load_en together with up_bit=1 or dn_bit=1 and expects the loaded value, never the value one step away. It also loads 2^N-2 and 1, then steps past each bound, and expects the counter to stop at the bound. A scoreboard model predicts every post-edge count and stream bit, including over a long random run.

// File: rtl/sc_integ_pkg.sv
package sc_integ_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/sc_rst_sync.sv
module sc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_q_n = stage2_q;
endmodule

// File: rtl/sc_step_decode.sv
module sc_step_decode
  import sc_integ_pkg::*;
(
  input  logic  up_bit,
  input  logic  dn_bit,
  output step_e step
);
  always_comb begin
    unique case ({up_bit, dn_bit})
      2'b10:   step = STEP_UP;
      2'b01:   step = STEP_DOWN;
      default: step = STEP_HOLD;
    endcase
  end
endmodule

// File: rtl/sc_sat_counter.sv
module sc_sat_counter
  import sc_integ_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [N-1:0] load_val,
  input  step_e        step,
  output logic [N-1:0] count
);
  localparam logic [N-1:0] TOP_VAL = {N{1'b1}};
  localparam logic [N-1:0] BOT_VAL = {N{1'b0}};

  logic [N-1:0] count_q;
  logic [N-1:0] count_d;
  logic         count_en;

  always_comb begin
    count_d  = count_q;
    count_en = 1'b0;
    if (load_en) begin
      count_d  = load_val;
      count_en = 1'b1;
    end else begin
      unique case (step)
        STEP_UP: begin
          if (count_q != TOP_VAL) begin
            count_d  = count_q + 1'b1;
            count_en = 1'b1;
          end
        end
        STEP_DOWN: begin
          if (count_q != BOT_VAL) begin
            count_d  = count_q - 1'b1;
            count_en = 1'b1;
          end
        end
        default: begin
          count_d  = count_q;
          count_en = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= BOT_VAL;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign count = count_q;
endmodule

// File: rtl/sc_out_compare.sv
module sc_out_compare #(
  parameter int N = 8
) (
  input  logic [N-1:0] count,
  input  logic [N-1:0] rand_word,
  output logic         stream_bit
);
  always_comb begin
    stream_bit = (count > rand_word);
  end
endmodule

// File: rtl/sc_integrator.sv
module sc_integrator
  import sc_integ_pkg::*;
#(
  parameter int N      = 8,
  parameter bit OUT_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [N-1:0] load_val,
  input  logic         up_bit,
  input  logic         dn_bit,
  input  logic [N-1:0] rand_word,
  output logic [N-1:0] count,
  output logic         stream_bit
);
  logic  rst_q_n;
  step_e step;

  sc_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  sc_step_decode u_decode (
    .up_bit (up_bit),
    .dn_bit (dn_bit),
    .step   (step)
  );

  sc_sat_counter #(.N(N)) u_counter (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load_en  (load_en),
    .load_val (load_val),
    .step     (step),
    .count    (count)
  );

  generate
    if (OUT_EN) begin : g_out
      sc_out_compare #(.N(N)) u_cmp (
        .count      (count),
        .rand_word  (rand_word),
        .stream_bit (stream_bit)
      );
    end else begin : g_no_out
      assign stream_bit = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/sc_integrator_chk.sv
module sc_integrator_chk #(
  parameter int N      = 8,
  parameter bit OUT_EN = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_en,
  input logic [N-1:0] load_val,
  input logic         up_bit,
  input logic         dn_bit,
  input logic [N-1:0] rand_word,
  input logic [N-1:0] count,
  input logic         stream_bit
);
  localparam logic [N-1:0] TOP_VAL = {N{1'b1}};
  localparam logic [N-1:0] BOT_VAL = {N{1'b0}};

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_up_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!load_en && up_bit && !dn_bit && (count != TOP_VAL)))
      |-> (count == $past(count) + 1'b1));

  assert_down_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!load_en && !up_bit && dn_bit && (count != BOT_VAL)))
      |-> (count == $past(count) - 1'b1));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!load_en && (up_bit == dn_bit)))
      |-> $stable(count));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!load_en && up_bit && !dn_bit && (count == TOP_VAL)))
      |-> (count == TOP_VAL));

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!load_en && !up_bit && dn_bit && (count == BOT_VAL)))
      |-> (count == BOT_VAL));

  assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(load_en)) |-> (count == $past(load_val)));

  generate
    if (OUT_EN) begin : g_out_chk
      assert_zero_count_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count == BOT_VAL) |-> !stream_bit);
      assert_full_count_fires_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((count == TOP_VAL) && (rand_word != TOP_VAL)) |-> stream_bit);
    end else begin : g_no_out_chk
      assert_removed_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stream_bit);
    end
  endgenerate
endmodule

bind sc_integrator sc_integrator_chk #(.N(N), .OUT_EN(OUT_EN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .load_en    (load_en),
  .load_val   (load_val),
  .up_bit     (up_bit),
  .dn_bit     (dn_bit),
  .rand_word  (rand_word),
  .count      (count),
  .stream_bit (stream_bit)
);

// File: tb/sc_integrator_tb.sv
module sc_integrator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk;
  logic         rst_n;
  logic         load_en;
  logic [N-1:0] load_val;
  logic         up_bit;
  logic         dn_bit;
  logic [N-1:0] rand_word;
  logic [N-1:0] count;
  logic         stream_bit;
  logic [N-1:0] count_bare;
  logic         stream_bare;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;
  int exp_count = 0;

  typedef struct {
    int    cnt;
    bit    sbit;
    string req;
  } item_t;

  item_t sb_q[$];
  event  item_ev;

  sc_integrator #(.N(N), .OUT_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
    .up_bit(up_bit), .dn_bit(dn_bit), .rand_word(rand_word),
    .count(count), .stream_bit(stream_bit)
  );

  sc_integrator #(.N(N), .OUT_EN(1'b0)) u_dut_bare (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
    .up_bit(up_bit), .dn_bit(dn_bit), .rand_word(rand_word),
    .count(count_bare), .stream_bit(stream_bare)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // monitor: pops expected items and compares with the design outputs
  always @(item_ev) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(int'(count) == it.cnt, {it.req, " count"}, int'(count), it.cnt);
      check(stream_bit == it.sbit, "R8 stream_bit", int'(stream_bit), int'(it.sbit));
      check(stream_bare == 1'b0, "R8 removed stage", int'(stream_bare), 0);
    end
  end

  // driver: apply one cycle of stimulus, model it, queue the expectation
  task automatic drive(input bit ld, input int lv, input bit a, input bit b,
                       input int r, input string req);
    @(negedge clk);
    load_en   = ld;
    load_val  = lv[N-1:0];
    up_bit    = a;
    dn_bit    = b;
    rand_word = r[N-1:0];
    if (ld) exp_count = lv;
    else if (a && !b && exp_count < (1 << N) - 1) exp_count++;
    else if (!a && b && exp_count > 0) exp_count--;
    @(posedge clk);
    #(CLK_PERIOD/4);
    sb_q.push_back('{exp_count, (exp_count > r), req});
    -> item_ev;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    int ups;
    int downs;
    int base;
    rst_n = 1'b0; load_en = 1'b0; load_val = '0;
    up_bit = 1'b1; dn_bit = 1'b0; rand_word = '0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    // R1: reset state even while the up stream is active
    check(count == '0, "R1 count in reset", int'(count), 0);
    check(stream_bit == 1'b0, "R1 stream in reset", int'(stream_bit), 0);
    @(negedge clk);
    up_bit = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check(count == '0, "R1 count after release", int'(count), 0);
    check(stream_bit == 1'b0, "R1 stream after release", int'(stream_bit), 0);

    drive(1, 10, 0, 0, 5, "R7 load");
    drive(0, 0, 1, 0, 10, "R2 up");
    drive(0, 0, 1, 0, 200, "R2 up");
    drive(0, 0, 0, 1, 3, "R3 down");
    drive(0, 0, 0, 0, 11, "R4 hold 00");
    drive(0, 0, 1, 1, 12, "R4 hold 11");
    drive(1, 77, 1, 0, 76, "R7 load beats up");
    drive(1, 33, 0, 1, 33, "R7 load beats down");
    drive(1, 254, 0, 0, 0, "R7 load near top");
    drive(0, 0, 1, 0, 254, "R2 up to top");
    drive(0, 0, 1, 0, 255, "R5 saturate top");
    drive(0, 0, 1, 0, 100, "R5 saturate top");
    drive(1, 1, 0, 0, 0, "R7 load near bottom");
    drive(0, 0, 0, 1, 0, "R3 down to bottom");
    drive(0, 0, 0, 1, 0, "R6 saturate bottom");
    drive(0, 0, 0, 1, 200, "R6 saturate bottom");

    // R9: running estimate over a random stream with no bound reached
    drive(1, 128, 0, 0, 64, "R7 load mid");
    base = 128; ups = 0; downs = 0;
    for (int i = 0; i < 100; i++) begin
      bit a;
      bit b;
      a = 1'($urandom);
      b = 1'($urandom);
      if (a && !b) ups++;
      if (!a && b) downs++;
      drive(0, 0, a, b, int'($urandom % 256), "R9 random step");
    end
    check(int'(count) == base + ups - downs, "R9 running estimate",
          int'(count), base + ups - downs);

    // random mix with loads and bounds
    for (int i = 0; i < 300; i++) begin
      bit ld;
      ld = (($urandom % 16) == 0);
      drive(ld, int'($urandom % 256), 1'($urandom), 1'($urandom),
            int'($urandom % 256), "R2 R3 R4 R7 random mix");
    end

    // R1 again: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(count == '0, "R1 count on reset assert", int'(count), 0);
    check(count_bare == '0, "R1 bare count on reset", int'(count_bare), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule